// File: doc/BRIEF.md
# Load Result Formatter

This block turns the raw bytes fetched by a fixed-point load into the value written to the destination register. The fetched bytes arrive packed at the low end of the data input in storage order: the byte at the lowest address is the most significant byte of the accessed item. A size code selects how many bytes are meaningful. Two mode inputs select sign extension and byte reversal. When neither is set, the result is zero-extended.

The formatted result, with a valid strobe, appears one clock after the request. Some size and mode pairings have no meaning. Sign extension of a single byte is one such case, and so is byte reversal combined with sign extension. For these pairings the block raises an error flag and drives a zero result. The register width is a parameter, `XW`. The largest legal size is the one that fills `XW` bits. Bits are numbered with the most significant bit on the left, so the least significant byte is `out_data[7:0]`.

Size encoding on `ld_size`: 0 = byte, 1 = halfword, 2 = word, 3 = doubleword.

Top module: `load_fmt`

## Requirements
- R1: When `ld_size`=0 and both modes are clear, `out_data[7:0]` equals `raw_data[7:0]` and all higher bits are zero.
- R2: When `ld_size`=1 and both modes are clear, `out_data[15:0]` equals `raw_data[15:0]` and all higher bits are zero.
- R3: When `ld_size`=2 and both modes are clear, `out_data[31:0]` equals `raw_data[31:0]` and all higher bits are zero.
- R4: When `ld_size`=1 and `ld_sext`=1, `out_data[15:0]` equals `raw_data[15:0]` and every higher bit equals `raw_data[15]`.
- R5: When `ld_size`=2 and `ld_sext`=1, `out_data[31:0]` equals `raw_data[31:0]` and every higher bit equals `raw_data[31]`.
- R6: When `ld_size`=1 and `ld_brev`=1, `out_data[15:8]` equals `raw_data[7:0]`, `out_data[7:0]` equals `raw_data[15:8]`, and all higher bits are zero.
- R7: When `ld_size`=2 and `ld_brev`=1, byte k of `out_data` (bits 8k+7..8k) equals byte 3-k of `raw_data` for k = 0..3, and all higher bits are zero.
- R8: When `ld_size`=3 and `XW`=64, the data passes through unchanged if both modes are clear. If `ld_brev`=1, byte k of the result equals byte 7-k of `raw_data`.
- R9: A request is illegal if any of the following holds: `ld_sext` with size 0 or 3; `ld_brev` with size 0; both modes set together; a size wider than `XW`. An illegal request sets `out_err`=1 and `out_data`=0 on the output cycle.
- R10: `out_valid` equals `in_valid` delayed by one clock. `out_err` is 1 only with `out_valid`. In a cycle without a valid output, `out_data` is zero.
- R11: While `rst_n` is low, and in the first cycle after it rises, `out_valid`, `out_err` and `out_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| raw_data | input | XW | Fetched bytes, packed low, storage order |
| ld_size | input | 2 | Access size code |
| ld_sext | input | 1 | Sign-extend mode |
| ld_brev | input | 1 | Byte-reverse mode |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_data | output | XW | Formatted register value |
| out_err | output | 1 | Illegal size/mode pairing |

## Verification
The bench builds two copies side by side and gives both the same stimulus. The first uses `XW`=64, which brings every size, including the full doubleword reversal, within reach. The second uses `XW`=32, where the word is the widest legal size and a doubleword request must be flagged as too wide. In that copy, word sign extension fills nothing above bit 31. Random requests cover every size and mode pairing, the boundary sign bits, and gaps in the strobe.

// File: rtl/load_fmt.sv
module load_fmt #(
  parameter int XW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [XW-1:0] raw_data,
  input  logic [1:0]    ld_size,
  input  logic          ld_sext,
  input  logic          ld_brev,
  output logic          out_valid,
  output logic [XW-1:0] out_data,
  output logic          out_err
);
  localparam int NB = XW / 8;
  localparam logic [1:0] MAXSZ = 2'($clog2(NB));

  logic [XW-1:0] shaped;
  logic          illegal;
  logic          top_bit;
  int            nbytes;

  assign nbytes  = 1 << ld_size;
  assign illegal = (ld_size > MAXSZ)
                 | (ld_sext & (ld_size == 2'd0 || ld_size == 2'd3))
                 | (ld_brev & (ld_size == 2'd0))
                 | (ld_sext & ld_brev);

  always_comb begin
    shaped = '0;
    for (int i = 0; i < NB; i++) begin
      if (i < nbytes)
        shaped[8*i +: 8] = ld_brev ? raw_data[8*(nbytes-1-i) +: 8] : raw_data[8*i +: 8];
    end
    top_bit = shaped[8*nbytes-1];
    for (int i = 0; i < NB; i++) begin
      if (i >= nbytes)
        shaped[8*i +: 8] = {8{ld_sext & top_bit}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid & illegal;
      out_data  <= (in_valid & ~illegal) ? shaped : '0;
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid)); // R10
  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == '0); // R10
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_data == '0); // R9
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ld_size == 2'd0 && !ld_sext && !ld_brev
    |=> out_data[XW-1:8] == '0 && out_data[7:0] == $past(raw_data[7:0])); // R1
  AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ld_size == 2'd2 && ld_sext && !ld_brev
    |=> out_data[31:0] == $past(raw_data[31:0]) &&
        (out_data[XW-1:31] == '0 || out_data[XW-1:31] == '1)); // R5
  AST_HALF_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ld_size == 2'd1 && ld_brev && !ld_sext
    |=> out_data[15:0] == {$past(raw_data[7:0]), $past(raw_data[15:8])}); // R6
  AST_BAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ld_sext && ld_brev |=> out_err); // R9
endmodule

// File: tb/load_fmt_tb.sv
module load_fmt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] raw = '0;
  logic [1:0]  sz = '0;
  logic        sx = 1'b0;
  logic        br = 1'b0;
  logic        v64, e64, v32, e32;
  logic [63:0] d64;
  logic [31:0] d32;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  load_fmt #(.XW(64)) u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .raw_data(raw), .ld_size(sz), .ld_sext(sx), .ld_brev(br),
    .out_valid(v64), .out_data(d64), .out_err(e64));
  load_fmt #(.XW(32)) u_dut_w32 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .raw_data(raw[31:0]), .ld_size(sz), .ld_sext(sx), .ld_brev(br),
    .out_valid(v32), .out_data(d32), .out_err(e32));

  function automatic logic [64:0] model(logic [63:0] r, logic [1:0] s, logic x, logic b, int w);
    logic bad;
    logic [63:0] y;
    bad = (w == 32 && s == 2'd3) || (x && (s == 2'd0 || s == 2'd3)) || (b && s == 2'd0) || (x && b);
    case (s)
      2'd0: y = {56'd0, r[7:0]};
      2'd1: y = b ? {48'd0, r[7:0], r[15:8]} : x ? {{48{r[15]}}, r[15:0]} : {48'd0, r[15:0]};
      2'd2: y = b ? {32'd0, r[7:0], r[15:8], r[23:16], r[31:24]}
              : x ? {{32{r[31]}}, r[31:0]} : {32'd0, r[31:0]};
      default: y = b ? {r[7:0], r[15:8], r[23:16], r[31:24], r[39:32], r[47:40], r[55:48], r[63:56]} : r;
    endcase
    if (bad) y = '0;
    if (w == 32) y[63:32] = '0;
    return {bad, y};
  endfunction

  function automatic string tag(logic [1:0] s, logic x, logic b, logic bad);
    if (bad) return "R9";
    if (s == 2'd0) return "R1";
    if (s == 2'd3) return "R8";
    if (b) return (s == 2'd1) ? "R6" : "R7";
    if (x) return (s == 2'd1) ? "R4" : "R5";
    return (s == 2'd1) ? "R2" : "R3";
  endfunction

  task automatic check(string req, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [63:0] r, logic [1:0] s, logic x, logic b);
    logic [64:0] m64, m32;
    in_valid = 1'b1; raw = r; sz = s; sx = x; br = b;
    m64 = model(r, s, x, b, 64);
    m32 = model(r, s, x, b, 32);
    @(negedge clk);
    check(tag(s, x, b, m64[64]), {e64, d64}, m64);
    check(tag(s, x, b, m32[64]), {e32, 32'd0, d32}, m32);
    check("R10", {63'd0, v64, v32}, {63'd0, 1'b1, 1'b1});
  endtask

  task automatic idle();
    in_valid = 1'b0; raw = {$urandom, $urandom}; sz = 2'($urandom); sx = 1'($urandom); br = 1'($urandom);
    @(negedge clk);
    check("R10", {v64, e64, d64}, 65'd0);
    check("R10", {30'd0, v32, e32, d32}, 65'd0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    in_valid = 1'b1; raw = '1; sz = 2'd3;
    repeat (2) @(negedge clk);
    check("R11", {v64, e64, d64}, 65'd0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R11", {v64, e64, d64}, 65'd0);
    issue(64'h0123_4567_89ab_cdef, 2'd0, 0, 0);
    issue(64'hffff_ffff_ffff_8001, 2'd1, 0, 0);
    issue(64'h0000_0000_9abc_def0, 2'd2, 0, 0);
    issue(64'h0000_0000_0000_8000, 2'd1, 1, 0);
    issue(64'hffff_ffff_ffff_7fff, 2'd1, 1, 0);
    issue(64'h0000_0000_8000_0000, 2'd2, 1, 0);
    issue(64'hffff_ffff_7fff_ffff, 2'd2, 1, 0);
    issue(64'h1111_2222_3333_a1b2, 2'd1, 0, 1);
    issue(64'h5555_6666_1122_3344, 2'd2, 0, 1);
    issue(64'h0102_0304_0506_0708, 2'd3, 0, 1);
    issue(64'h8877_6655_4433_2211, 2'd3, 0, 0);
    issue(64'hdead_beef_cafe_f00d, 2'd0, 1, 0);
    issue(64'hdead_beef_cafe_f00d, 2'd0, 0, 1);
    issue(64'hdead_beef_cafe_f00d, 2'd3, 1, 0);
    issue(64'hdead_beef_cafe_f00d, 2'd2, 1, 1);
    idle();
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 7) == 0) idle();
      else issue({$urandom, $urandom}, 2'($urandom), 1'($urandom), 1'($urandom));
    end
    idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule